// File: doc/BRIEF.md
# TDC Hit Trigger-Matching Event Builder

This block sits behind a bank of multi-hit time-to-digital converter channels. Every hit arrives as a channel number with a time stamp from a free-running time counter. The block writes each hit into a circular buffer as it arrives and keeps it there until a trigger request either claims it or shows that it is stale. The hit time is one counter value, with the coarse part in the upper bits and the fine part in the lower bits.

A trigger request gives a trigger time and 16 bits of trigger data. The block goes back a fixed latency from the trigger time to get the start of the window. It then walks the buffer from its oldest entry. Entries older than the window start are discarded. Entries inside the window become 32-bit records that carry the time relative to the window start. The first entry newer than the window ends the walk and stays in the buffer for later triggers.

The event is framed by a three-word header and a three-word trailer. All words go into an output FIFO, which a downstream reader drains one word at a time. The trailer holds the number of records written and an overflow flag.

Top module: `tdc_trig_match`

## Requirements
- R1: After reset, `out_valid` and `busy` are low, and the first event carries frame number 0.
- R2: The circular buffer holds up to DEPTH hits in arrival order. A hit that arrives while the buffer is full is dropped.
- R3: A buffered hit with time t matches a trigger with time T when (t − (T − LATENCY)) mod 2^18 < WINDOW.
- R4: A hit record has the relative time (t − window start, mod 2^18) in bits 17:0, the channel in bits 23:18, and zero in bits 31:24. Records follow buffer order.
- R5: The header is three words, in this order: {8'hA5, 8'h00, BOARD_ID[15:0]}; the 32-bit frame number, which rises by one per accepted trigger; and {14'b0, window start[17:0]}.
- R6: The trailer is three words, in this order: {8'h5A, 8'h00, trigger data[15:0]}; the count of records written; and an error word with the overflow flag in bit 0 and zeros elsewhere.
- R7: During the walk, entries older than the window start (the MSB of the mod-2^18 difference is set) are removed from the buffer. The first entry at or after the window end stops the walk and is kept, together with everything behind it.
- R8: When the output FIFO is full, a matched record is dropped, it is not counted, and the overflow flag is set. Header and trailer words wait for room and are never dropped.
- R9: A trigger with no matching hit produces a six-word event whose record count is 0.
- R10: A trigger request that arrives while `busy` is high is ignored: it produces no event and does not change the frame number.
- R11: Output words stay presented until `out_ready` is high, and they leave in the order they were produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_chan | input | 6 | Channel number of the hit |
| hit_time | input | 18 | Hit time stamp (coarse and fine), non-decreasing |
| trig_valid | input | 1 | Trigger request |
| trig_time | input | 18 | Time stamp of the trigger |
| trig_data | input | 16 | Trigger data copied into the trailer |
| busy | output | 1 | An event is being built |
| out_valid | output | 1 | The output FIFO holds a word |
| out_data | output | 32 | Oldest word in the output FIFO |
| out_ready | input | 1 | The reader takes the word this cycle |

## Verification
The assertions check these rules on every cycle:
- the buffer never holds more than DEPTH entries and is never popped when empty;
- the FIFO is never written while full;
- every record written has its reserved byte clear and a relative time below WINDOW;
- the frame number stays fixed when a trigger arrives during a busy period.

Only the bench scenarios can show the rest:
- which hits fall in or out of a window, including across counter wrap;
- that stale entries are gone and newer entries survive for the next trigger;
- the exact word count and overflow flag after a stalled reader;
- that a hit offered to a full buffer is dropped.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam int TIME_W = 18;
    localparam int CHAN_W = 6;
    localparam int WORD_W = 32;

    localparam logic [7:0] HDR_TAG = 8'hA5;
    localparam logic [7:0] TRL_TAG = 8'h5A;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [TIME_W-1:0] t;
    } hit_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_H0, ST_H1, ST_H2, ST_SCAN, ST_T0, ST_T1, ST_T2
    } fr_state_e;

    function automatic logic [WORD_W-1:0] mk_record(input logic [CHAN_W-1:0] ch,
                                                    input logic [TIME_W-1:0] rel);
        return {{(WORD_W-TIME_W-CHAN_W){1'b0}}, ch, rel};
    endfunction
endpackage

// File: rtl/tm_hit_ring.sv
module tm_hit_ring
    import tm_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  hit_t          wr_hit,
    input  logic          pop,
    input  logic [CW-1:0] rd_off,
    output hit_t          rd_hit,
    output logic [CW-1:0] count
);
    hit_t          mem [DEPTH];
    logic [AW-1:0] tail_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign accept = wr_en && (cnt_q < CW'(DEPTH));
    assign count  = cnt_q;
    assign rd_hit = mem[tail_q + rd_off[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (accept) mem[tail_q + cnt_q[AW-1:0]] <= wr_hit;
            if (pop) tail_q <= tail_q + AW'(1);
            cnt_q <= cnt_q + CW'(accept) - CW'(pop);
        end
    end

    p_ring_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt_q != '0);
endmodule

// File: rtl/tm_out_fifo.sv
module tm_out_fifo
    import tm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    output logic              full,
    output logic              valid,
    output logic [WORD_W-1:0] data,
    input  logic              ready
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     rd_q, wr_q;
    logic [CW-1:0]     cnt_q;
    logic              pop;

    assign full  = (cnt_q == CW'(DEPTH));
    assign valid = (cnt_q != '0);
    assign data  = mem[rd_q];
    assign pop   = valid && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= push_data;
                wr_q      <= wr_q + AW'(1);
            end
            if (pop) rd_q <= rd_q + AW'(1);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    p_no_push_full_r8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
endmodule

// File: rtl/tm_framer.sv
module tm_framer
    import tm_pkg::*;
#(
    parameter int          RING_DEPTH = 32,
    parameter int          LATENCY    = 200,
    parameter int          WINDOW     = 12,
    parameter logic [15:0] BOARD_ID   = 16'h0B01,
    localparam int CW = $clog2(RING_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_valid,
    input  logic [TIME_W-1:0] trig_time,
    input  logic [15:0]       trig_data,
    input  hit_t              ent,
    input  logic [CW-1:0]     ring_count,
    output logic [CW-1:0]     rd_off,
    output logic              ring_pop,
    input  logic              fifo_full,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              busy
);
    fr_state_e         st_q, st_d;
    logic [TIME_W-1:0] ws_q, rel;
    logic [15:0]       tdata_q;
    logic [31:0]       frame_q, wcnt_q;
    logic              ovf_q;
    logic [CW-1:0]     k_q;
    logic              is_match, is_old, at_end, rec_push, rec_drop, skip;

    assign rel      = ent.t - ws_q;
    assign at_end   = (k_q == ring_count);
    assign is_match = (rel < TIME_W'(WINDOW));
    assign is_old   = rel[TIME_W-1];
    assign rd_off   = k_q;
    assign busy     = (st_q != ST_IDLE);

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        push_data = '0;
        ring_pop  = 1'b0;
        rec_push  = 1'b0;
        rec_drop  = 1'b0;
        skip      = 1'b0;
        unique case (st_q)
            ST_IDLE: if (trig_valid) st_d = ST_H0;
            ST_H0: begin
                push_data = {HDR_TAG, 8'h00, BOARD_ID};
                push = !fifo_full;
                if (push) st_d = ST_H1;
            end
            ST_H1: begin
                push_data = frame_q;
                push = !fifo_full;
                if (push) st_d = ST_H2;
            end
            ST_H2: begin
                push_data = {{(WORD_W-TIME_W){1'b0}}, ws_q};
                push = !fifo_full;
                if (push) st_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (at_end) st_d = ST_T0;
                else if (is_match) begin
                    push_data = mk_record(ent.chan, rel);
                    rec_push  = !fifo_full;
                    rec_drop  = fifo_full;
                    push      = rec_push;
                    skip      = 1'b1;
                end else if (is_old) begin
                    if (k_q == '0) ring_pop = 1'b1;
                    else skip = 1'b1;
                end else st_d = ST_T0;
            end
            ST_T0: begin
                push_data = {TRL_TAG, 8'h00, tdata_q};
                push = !fifo_full;
                if (push) st_d = ST_T1;
            end
            ST_T1: begin
                push_data = wcnt_q;
                push = !fifo_full;
                if (push) st_d = ST_T2;
            end
            ST_T2: begin
                push_data = {31'b0, ovf_q};
                push = !fifo_full;
                if (push) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ws_q    <= '0;
            tdata_q <= '0;
            frame_q <= '0;
            wcnt_q  <= '0;
            ovf_q   <= 1'b0;
            k_q     <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && trig_valid) begin
                ws_q    <= trig_time - TIME_W'(LATENCY);
                tdata_q <= trig_data;
                wcnt_q  <= '0;
                ovf_q   <= 1'b0;
                k_q     <= '0;
            end
            if (st_q == ST_T2 && push) frame_q <= frame_q + 32'd1;
            if (skip) k_q <= k_q + CW'(1);
            if (rec_push) wcnt_q <= wcnt_q + 32'd1;
            if (rec_drop) ovf_q <= 1'b1;
        end
    end

    p_rec_reserved_r4: assert property (@(posedge clk) disable iff (rst)
        rec_push |-> push_data[WORD_W-1:TIME_W+CHAN_W] == '0);
    p_rec_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        rec_push |-> push_data[TIME_W-1:0] < TIME_W'(WINDOW));
    p_busy_trig_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (trig_valid && busy && st_q != ST_T2) |=> $stable(frame_q));
endmodule

// File: rtl/tdc_trig_match.sv
module tdc_trig_match
    import tm_pkg::*;
#(
    parameter int          RING_DEPTH = 32,
    parameter int          FIFO_DEPTH = 16,
    parameter int          LATENCY    = 200,
    parameter int          WINDOW     = 12,
    parameter logic [15:0] BOARD_ID   = 16'h0B01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hit_valid,
    input  logic [5:0]  hit_chan,
    input  logic [17:0] hit_time,
    input  logic        trig_valid,
    input  logic [17:0] trig_time,
    input  logic [15:0] trig_data,
    output logic        busy,
    output logic        out_valid,
    output logic [31:0] out_data,
    input  logic        out_ready
);
    localparam int CW = $clog2(RING_DEPTH + 1);

    hit_t              wr_hit, rd_hit;
    logic              pop, push, full;
    logic [CW-1:0]     rd_off, count;
    logic [WORD_W-1:0] push_data;

    assign wr_hit = '{chan: hit_chan, t: hit_time};

    tm_hit_ring #(.DEPTH(RING_DEPTH)) u_ring (
        .clk(clk), .rst(rst), .wr_en(hit_valid), .wr_hit(wr_hit),
        .pop(pop), .rd_off(rd_off), .rd_hit(rd_hit), .count(count)
    );

    tm_framer #(.RING_DEPTH(RING_DEPTH), .LATENCY(LATENCY), .WINDOW(WINDOW),
                .BOARD_ID(BOARD_ID)) u_framer (
        .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_time(trig_time),
        .trig_data(trig_data), .ent(rd_hit), .ring_count(count), .rd_off(rd_off),
        .ring_pop(pop), .fifo_full(full), .push(push), .push_data(push_data),
        .busy(busy)
    );

    tm_out_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data), .full(full),
        .valid(out_valid), .data(out_data), .ready(out_ready)
    );
endmodule

// File: tb/tdc_trig_match_tb.sv
module tdc_trig_match_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RDEPTH = 32;
    localparam int FDEPTH = 16;
    localparam int LAT = 200;
    localparam int WIN = 12;
    localparam logic [15:0] BID = 16'h0B01;

    logic        clk = 0, rst = 1;
    logic        hit_valid = 0, trig_valid = 0, out_ready = 1;
    logic [5:0]  hit_chan = 0;
    logic [17:0] hit_time = 0, trig_time = 0;
    logic [15:0] trig_data = 0;
    logic        busy, out_valid;
    logic [31:0] out_data;

    int n_chk = 0, n_err = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [23:0] model[$];   // {chan, time}
    int unsigned frame_n = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdc_trig_match #(.RING_DEPTH(RDEPTH), .FIFO_DEPTH(FDEPTH), .LATENCY(LAT),
                     .WINDOW(WIN), .BOARD_ID(BID)) u_dut (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_chan(hit_chan),
        .hit_time(hit_time), .trig_valid(trig_valid), .trig_time(trig_time),
        .trig_data(trig_data), .busy(busy), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_word(input logic [31:0] w, input string req);
        exp_q.push_back(w);
        tag_q.push_back(req);
    endtask

    // Monitor: pops the scoreboard on every word the reader takes
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) check("R11 unexpected word", out_data, 32'hxxxxxxxx);
            else check(tag_q.pop_front(), out_data, exp_q.pop_front());
        end
    end

    task automatic send_hit(input logic [5:0] ch, input logic [17:0] t);
        @(posedge clk); #1;
        hit_valid = 1; hit_chan = ch; hit_time = t;
        if (model.size() < RDEPTH) model.push_back({ch, t});   // R2 drop when full
        @(posedge clk); #1;
        hit_valid = 0;
    endtask

    // Driver: issues a trigger and pushes the expected event
    task automatic trigger(input logic [17:0] tt, input logic [15:0] td, input int cap);
        logic [17:0] ws, rel;
        int nrec = 0;
        bit ovf = 0;
        ws = tt - 18'(LAT);
        expect_word({8'hA5, 8'h00, BID}, "R5 header tag");
        expect_word(frame_n, "R5 frame number");
        expect_word({14'b0, ws}, "R5 window start");
        while (model.size() > 0) begin
            rel = model[0][17:0] - ws;
            if (rel[17] && !(rel < 18'(WIN))) void'(model.pop_front());   // R7 old
            else break;
        end
        foreach (model[i]) begin
            rel = model[i][17:0] - ws;
            if (rel < 18'(WIN)) begin                                   // R3 match
                if (nrec < cap) begin
                    expect_word({8'h00, model[i][23:18], rel}, "R4 record");
                    nrec++;
                end else ovf = 1;                                       // R8
            end else break;                                             // R7 newer
        end
        expect_word({8'h5A, 8'h00, td}, "R6 trailer tag");
        expect_word(nrec, "R6 word count");
        expect_word({31'b0, ovf}, "R6 error code");
        frame_n++;
        @(posedge clk); #1;
        trig_valid = 1; trig_time = tt; trig_data = td;
        @(posedge clk); #1;
        trig_valid = 0;
    endtask

    task automatic wait_drain();
        int guard = 0;
        while ((busy || exp_q.size() != 0) && guard < 2000) begin
            @(posedge clk); guard++;
        end
        check("R11 event drained", exp_q.size(), 0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 busy after reset", busy, 0);

        // R3 R7: stale hit dropped, window edges
        send_hit(6'd1, 18'd50);
        send_hit(6'd2, 18'd210);
        send_hit(6'd3, 18'd215);
        send_hit(6'd4, 18'd221);
        send_hit(6'd5, 18'd222);
        trigger(18'd410, 16'h1111, 1000);
        wait_drain();
        trigger(18'd422, 16'h2222, 1000);   // matches kept newer hit
        wait_drain();
        // R9: empty event, also shows hit at 50 was discarded
        trigger(18'd250, 16'h3333, 1000);
        wait_drain();
        trigger(18'd1300, 16'h4444, 1000);  // flush: ws=1100
        wait_drain();

        // R10: trigger during busy is ignored
        trigger(18'd1400, 16'h5555, 1000);
        @(negedge clk);
        check("R10 busy while building", busy, 1);
        @(posedge clk); #1;
        trig_valid = 1; trig_time = 18'd1500; trig_data = 16'hBAD0;
        @(posedge clk); #1;
        trig_valid = 0;
        wait_drain();

        // R3 across counter wrap: ws = 262138
        send_hit(6'd7, 18'd262140);
        send_hit(6'd8, 18'd3);
        send_hit(6'd9, 18'd4);              // rel 10
        trigger(18'd194, 16'h6666, 1000);
        wait_drain();
        trigger(18'd900, 16'h6667, 1000);   // flush
        wait_drain();

        // R8 R11: stalled reader, FIFO overflow
        for (int i = 0; i < 20; i++) send_hit(6'(i), 18'd2000);
        @(posedge clk); #1;
        out_ready = 0;
        trigger(18'd2200, 16'h7777, FDEPTH - 3);
        repeat (80) @(posedge clk);
        @(negedge clk);
        check("R11 word held while stalled", out_valid, 1);
        check("R11 header held while stalled", out_data, {8'hA5, 8'h00, BID});
        @(posedge clk); #1;
        out_ready = 1;
        wait_drain();
        trigger(18'd4200, 16'h8888, 1000);  // flush
        wait_drain();

        // R2: 34 hits into a 32-entry buffer, last two dropped
        for (int i = 0; i < 34; i++) send_hit(6'(i), 18'd5000);
        trigger(18'd5200, 16'h9999, 1000);
        wait_drain();

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk); cyc++;
        end
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule